// File: doc/BRIEF.md
# Serial Port Status Flag Register

This block holds the five status flags of a simple serial port: transmit buffer empty, receive buffer full, and the overrun, parity and framing error flags. Events from the transmitter and receiver cores set the flags. A register bus reads them, and software can clear them but never set them. A DMA side channel also clears the two data flags when it moves a byte. The transmit and receive interrupt requests are derived from the data flags and gated by their enables.

Software clears a flag in two steps. It first reads the register while the flag is 1, which arms a per-flag latch. Its next write clears the flag if the written bit is 0. Any write disarms every latch. This stops a stale write from wiping out a flag that was raised after the last read.

Top module: `sio_stat_reg`

## Requirements
- R1: After reset, `reg_rdata` reads 0x01 (transmit-empty at bit 0 set, all other flags clear), and both interrupt requests are low.
- R2: Flag bits are bit 0 transmit-empty, bit 1 receive-full, bit 2 overrun, bit 3 parity error, bit 4 framing error. Bits 5 and up always read 0. Writing 1 to a flag bit never sets or clears that flag.
- R3: While `tx_en` is 0, the transmit-empty flag reads 1 in the following cycle. With `tx_en` at 1, a `tx_load` pulse sets it.
- R4: With `tx_en` at 1, a `dma_tx_wr` pulse clears transmit-empty, and a `dma_rx_rd` pulse clears receive-full.
- R5: A register write with bit i at 0 clears flag i only if a register read since the previous write saw flag i as 1. Any write disarms all flags.
- R6: A completed reception (`rx_done` with `rx_en` at 1) with no error while receive-full is 0 sets receive-full.
- R7: A completed reception while receive-full is 0 sets the parity and/or framing flag for each reported error, and then leaves receive-full at 0.
- R8: A completed reception while receive-full is 1 sets the overrun flag, discards the byte, and changes neither the parity nor the framing flag.
- R9: While `rx_en` is 0, `rx_done` is ignored, and receive-full keeps its value.
- R10: `tx_irq` equals transmit-empty AND `tx_irq_en`. `rx_irq` equals receive-full AND `rx_irq_en`.
- R11: When a set event and a clear (software or DMA) land on the same flag in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Transmitter enable |
| rx_en | input | 1 | Receiver enable |
| tx_irq_en | input | 1 | Transmit interrupt enable |
| rx_irq_en | input | 1 | Receive interrupt enable |
| tx_load | input | 1 | Byte moved from transmit data register to shifter |
| rx_done | input | 1 | Reception finished, byte ready for the data register |
| rx_par_err | input | 1 | Parity error on the finished reception |
| rx_frm_err | input | 1 | Framing error on the finished reception |
| dma_tx_wr | input | 1 | DMA wrote the transmit data register |
| dma_rx_rd | input | 1 | DMA read the receive data register |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Current flag values |
| tx_irq | output | 1 | Transmit interrupt request |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
Directed sequences run first:
- a write of all ones, with and without a prior read;
- a write of zero with no prior read;
- a read followed by a write of zero, and a second write after it;
- receptions with receive-full already set, and with each error kind;
- `rx_done` with the receiver disabled;
- DMA strobes.

These separate the armed-clear rule from a plain write-zero clear, and overrun from ordinary error reporting. A long stretch of biased random stimulus then collides set and clear events on the same flag. A behavioural model checks every flag and both interrupt requests against the design on every cycle.

// File: rtl/sio_stat_pkg.sv
package sio_stat_pkg;
    localparam int NFLAG = 5;
    localparam int TXE_B = 0;
    localparam int RXF_B = 1;
    localparam int OVR_B = 2;
    localparam int PAR_B = 3;
    localparam int FRM_B = 4;
    localparam int NERR  = 3;   // overrun, parity, framing
    typedef logic [NFLAG-1:0] flag_vec_t;
endpackage

// File: rtl/sio_arm_latch.sv
module sio_arm_latch #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rd,
    input  logic         wr,
    input  logic [N-1:0] flags,
    input  logic [N-1:0] wdata,
    output logic [N-1:0] clr
);
    typedef struct packed {
        logic [N-1:0] arm;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr)      st_d.arm = '0;
        else if (rd) st_d.arm = st_q.arm | flags;
        clr = {N{wr}} & st_q.arm & ~wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/sio_tx_flag.sv
module sio_tx_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_en,
    input  logic tx_load,
    input  logic dma_wr,
    input  logic sw_clr,
    output logic txe
);
    typedef struct packed {
        logic txe;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!tx_en)               st_d.txe = 1'b1;
        else if (tx_load)         st_d.txe = 1'b1;
        else if (dma_wr || sw_clr) st_d.txe = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{txe: 1'b1};
        else        st_q <= st_d;
    end

    assign txe = st_q.txe;
endmodule

// File: rtl/sio_sticky.sv
module sio_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic q
);
    typedef struct packed {
        logic v;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set)      st_d.v = 1'b1;
        else if (clr) st_d.v = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q = st_q.v;
endmodule

// File: rtl/sio_rx_flags.sv
module sio_rx_flags
    import sio_stat_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rx_en,
    input  logic            rx_done,
    input  logic            par_err,
    input  logic            frm_err,
    input  logic            dma_rd,
    input  logic            rxf_clr,
    input  logic [NERR-1:0] err_clr,   // {frm, par, ovr}
    output logic            rxf,
    output logic [NERR-1:0] err        // {frm, par, ovr}
);
    typedef struct packed {
        logic rxf;
    } st_t;

    st_t             st_d, st_q;
    logic            ev, good;
    logic [NERR-1:0] err_set;

    always_comb begin
        ev      = rx_en & rx_done;
        good    = ev & ~st_q.rxf;
        err_set = {good & frm_err, good & par_err, ev & st_q.rxf};
        st_d    = st_q;
        if (good && !par_err && !frm_err) st_d.rxf = 1'b1;
        else if (dma_rd || rxf_clr)       st_d.rxf = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rxf = st_q.rxf;

    for (genvar g = 0; g < NERR; g++) begin : g_err
        sio_sticky u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .set   (err_set[g]),
            .clr   (err_clr[g]),
            .q     (err[g])
        );
    end
endmodule

// File: rtl/sio_stat_reg.sv
module sio_stat_reg
    import sio_stat_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              rx_en,
    input  logic              tx_irq_en,
    input  logic              rx_irq_en,
    input  logic              tx_load,
    input  logic              rx_done,
    input  logic              rx_par_err,
    input  logic              rx_frm_err,
    input  logic              dma_tx_wr,
    input  logic              dma_rx_rd,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              tx_irq,
    output logic              rx_irq
);
    localparam int PAD_W = DATA_W - NFLAG;

    flag_vec_t       flags, clr;
    logic            txe, rxf;
    logic [NERR-1:0] err;

    sio_arm_latch #(.N(NFLAG)) u_arm (
        .clk   (clk),
        .rst_n (rst_n),
        .rd    (reg_rd),
        .wr    (reg_wr),
        .flags (flags),
        .wdata (reg_wdata[NFLAG-1:0]),
        .clr   (clr)
    );

    sio_tx_flag u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .tx_en   (tx_en),
        .tx_load (tx_load),
        .dma_wr  (dma_tx_wr),
        .sw_clr  (clr[TXE_B]),
        .txe     (txe)
    );

    sio_rx_flags u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .rx_en   (rx_en),
        .rx_done (rx_done),
        .par_err (rx_par_err),
        .frm_err (rx_frm_err),
        .dma_rd  (dma_rx_rd),
        .rxf_clr (clr[RXF_B]),
        .err_clr ({clr[FRM_B], clr[PAR_B], clr[OVR_B]}),
        .rxf     (rxf),
        .err     (err)
    );

    always_comb begin
        flags        = '0;
        flags[TXE_B] = txe;
        flags[RXF_B] = rxf;
        flags[OVR_B] = err[0];
        flags[PAR_B] = err[1];
        flags[FRM_B] = err[2];
    end

    assign reg_rdata = {{PAD_W{1'b0}}, flags};
    assign tx_irq    = tx_irq_en & txe;
    assign rx_irq    = rx_irq_en & rxf;
endmodule

// File: rtl/sio_stat_reg_chk.sv
module sio_stat_reg_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tx_en,
    input logic              rx_en,
    input logic              tx_load,
    input logic              rx_done,
    input logic              dma_tx_wr,
    input logic              dma_rx_rd,
    input logic              reg_wr,
    input logic [DATA_W-1:0] reg_rdata
);
    // R3
    txe_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> reg_rdata[0]);

    // R4
    dma_tx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && dma_tx_wr && !tx_load) |=> !reg_rdata[0]);

    // R6
    rxf_only_on_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_rdata[1] && !(rx_en && rx_done)) |=> !reg_rdata[1]);

    // R8
    overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && rx_done && reg_rdata[1]) |=> reg_rdata[2]);

    // R9
    rx_disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_en && reg_rdata[1] && !dma_rx_rd && !reg_wr) |=> reg_rdata[1]);

    // R2
    pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[DATA_W-1:5] == '0);
endmodule

bind sio_stat_reg sio_stat_reg_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_en     (tx_en),
    .rx_en     (rx_en),
    .tx_load   (tx_load),
    .rx_done   (rx_done),
    .dma_tx_wr (dma_tx_wr),
    .dma_rx_rd (dma_rx_rd),
    .reg_wr    (reg_wr),
    .reg_rdata (reg_rdata)
);

// File: tb/sio_stat_reg_bench.sv
`timescale 1ns/1ps
module sio_stat_reg_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_en = 0, rx_en = 0, tx_irq_en = 0, rx_irq_en = 0;
    logic       tx_load = 0, rx_done = 0, rx_par_err = 0, rx_frm_err = 0;
    logic       dma_tx_wr = 0, dma_rx_rd = 0, reg_rd = 0, reg_wr = 0;
    logic [7:0] reg_wdata = 0;
    logic [7:0] reg_rdata;
    logic       tx_irq, rx_irq;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    // behavioural model state
    int m_flag[5];
    int m_arm[5];

    always #5 clk = ~clk;

    sio_stat_reg u_sio_stat_reg (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .rx_en(rx_en),
        .tx_irq_en(tx_irq_en), .rx_irq_en(rx_irq_en), .tx_load(tx_load),
        .rx_done(rx_done), .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err),
        .dma_tx_wr(dma_tx_wr), .dma_rx_rd(dma_rx_rd), .reg_rd(reg_rd),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tx_irq(tx_irq), .rx_irq(rx_irq)
    );

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            foreach (m_flag[i]) begin m_flag[i] = 0; m_arm[i] = 0; end
            m_flag[0] = 1;
        end else begin
            int clr[5];
            int ev, full;
            foreach (clr[i]) clr[i] = (reg_wr && m_arm[i] && !reg_wdata[i]) ? 1 : 0;
            foreach (m_arm[i]) begin
                if (reg_wr) m_arm[i] = 0;
                else if (reg_rd && m_flag[i] == 1) m_arm[i] = 1;
            end
            if (!tx_en || tx_load) m_flag[0] = 1;
            else if (clr[0] || dma_tx_wr) m_flag[0] = 0;
            ev = (rx_en && rx_done) ? 1 : 0;
            full = m_flag[1];
            if (ev && full) m_flag[2] = 1;
            else if (clr[2]) m_flag[2] = 0;
            if (ev && !full && rx_par_err) m_flag[3] = 1;
            else if (clr[3]) m_flag[3] = 0;
            if (ev && !full && rx_frm_err) m_flag[4] = 1;
            else if (clr[4]) m_flag[4] = 0;
            if (ev && !full && !rx_par_err && !rx_frm_err) m_flag[1] = 1;
            else if (clr[1] || dma_rx_rd) m_flag[1] = 0;
        end
    end

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic compare_all();
        logic [7:0] exp;
        exp = {3'b000, m_flag[4][0], m_flag[3][0], m_flag[2][0], m_flag[1][0], m_flag[0][0]};
        check(reg_rdata[0] == exp[0], "R3 txe", reg_rdata[0], exp[0]);
        check(reg_rdata[1] == exp[1], "R6 rxf", reg_rdata[1], exp[1]);
        check(reg_rdata[2] == exp[2], "R8 ovr", reg_rdata[2], exp[2]);
        check(reg_rdata[4:3] == exp[4:3], "R7 par/frm", reg_rdata[4:3], exp[4:3]);
        check(reg_rdata[7:5] == 3'b0, "R2 pad", reg_rdata[7:5], 0);
        check(tx_irq == (tx_irq_en & exp[0]), "R10 tx_irq", tx_irq, tx_irq_en & exp[0]);
        check(rx_irq == (rx_irq_en & exp[1]), "R10 rx_irq", rx_irq, rx_irq_en & exp[1]);
    endtask

    task automatic idle();
        tx_load = 0; rx_done = 0; rx_par_err = 0; rx_frm_err = 0;
        dma_tx_wr = 0; dma_rx_rd = 0; reg_rd = 0; reg_wr = 0; reg_wdata = 0;
    endtask

    task automatic step();
        @(negedge clk);
        compare_all();
        idle();
    endtask

    task automatic rx(input logic p, input logic f);
        rx_done = 1; rx_par_err = p; rx_frm_err = f; step();
    endtask

    task automatic rd();  reg_rd = 1; step(); endtask
    task automatic wr(input logic [7:0] d); reg_wr = 1; reg_wdata = d; step(); endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset values
        check(reg_rdata == 8'h01, "R1 reset rdata", reg_rdata, 8'h01);
        check(tx_irq == 0 && rx_irq == 0, "R1 reset irqs", {tx_irq, rx_irq}, 0);
        tx_en = 1; rx_en = 1; tx_irq_en = 1; rx_irq_en = 1;
        step();
        // R2 writing ones cannot clear or set
        rd(); wr(8'hFF);
        check(reg_rdata == 8'h01, "R2 write ones", reg_rdata, 8'h01);
        // R4 dma clears txe
        dma_tx_wr = 1; step();
        check(reg_rdata[0] == 0, "R4 dma tx clear", reg_rdata[0], 0);
        wr(8'hFF);
        check(reg_rdata[0] == 0, "R2 write one no set", reg_rdata[0], 0);
        tx_load = 1; step();
        check(reg_rdata[0] == 1, "R3 tx_load sets", reg_rdata[0], 1);
        // R5 write zero without read
        wr(8'h00);
        check(reg_rdata[0] == 1, "R5 unarmed write", reg_rdata[0], 1);
        // R5 read then write zero
        rd(); wr(8'h00);
        check(reg_rdata[0] == 0, "R5 armed clear", reg_rdata[0], 0);
        // R3 tx disable forces
        tx_en = 0; step(); tx_en = 1;
        check(reg_rdata[0] == 1, "R3 forced", reg_rdata[0], 1);
        // R6 / R8
        rx(0, 0);
        check(reg_rdata[1] == 1 && rx_irq == 1, "R6 rxf set", reg_rdata[1], 1);
        rx(1, 1);
        check(reg_rdata[4:1] == 4'b0011, "R8 overrun only", reg_rdata[4:1], 4'b0011);
        // R9 rx disabled
        rx_en = 0; rx(0, 0);
        check(reg_rdata[1] == 1, "R9 rxf held", reg_rdata[1], 1);
        rx_en = 1;
        dma_rx_rd = 1; step();
        check(reg_rdata[1] == 0, "R4 dma rx clear", reg_rdata[1], 0);
        // R7 errors
        rx(1, 0);
        check(reg_rdata[4:1] == 4'b0110, "R7 parity", reg_rdata[4:1], 4'b0110);
        rx(0, 1);
        check(reg_rdata[4:1] == 4'b1110, "R7 framing", reg_rdata[4:1], 4'b1110);
        // R5 second write after clear is disarmed
        rd(); wr(8'hFB);
        check(reg_rdata[2] == 0, "R5 ovr clear", reg_rdata[2], 0);
        wr(8'h00);
        check(reg_rdata[4:3] == 2'b11, "R5 disarm after write", reg_rdata[4:3], 2'b11);
        // R11 set beats armed clear
        rd(); tx_load = 1; reg_wr = 1; reg_wdata = 8'h00; step();
        check(reg_rdata[0] == 1, "R11 set wins", reg_rdata[0], 1);
        // random phase, checked every cycle against the model
        for (int n = 0; n < 4000; n++) begin
            tx_en      = ($urandom % 16) != 0;
            rx_en      = ($urandom % 8) != 0;
            tx_irq_en  = $urandom % 2;
            rx_irq_en  = $urandom % 2;
            tx_load    = ($urandom % 5) == 0;
            rx_done    = ($urandom % 4) == 0;
            rx_par_err = ($urandom % 4) == 0;
            rx_frm_err = ($urandom % 4) == 0;
            dma_tx_wr  = ($urandom % 5) == 0;
            dma_rx_rd  = ($urandom % 5) == 0;
            reg_rd     = ($urandom % 3) == 0;
            reg_wr     = ($urandom % 3) == 0;
            reg_wdata  = 8'($urandom);
            @(negedge clk);
            compare_all();
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule